// File: doc/BRIEF.md
# Lockable One-Time Fuse Array Controller

This block keeps a 128-bit one-time-programmable fuse array as a register and decides, for every single-fuse burn request, whether that burn may happen. An unburned fuse reads 1 and a burned fuse reads 0. No operation can move a fuse back to 1. The upper 40 fuses hold a manufacturer identity byte and a 32-bit serial number. Parameters preload them at reset, and burn requests can never modify them.

The lowest eight fuses are lock fuses, stored inside the array they guard. Lock fuse k, once burned, freezes the 16-fuse group that starts at fuse 16k. Group 0 contains the lock fuses themselves, so burning lock fuse 0 freezes every lock fuse in its current state. Each request produces a one-cycle accept pulse or a one-cycle reject pulse. A 32-bit word-read port shows any quarter of the array at any time.

Top module: `fuse_otp_ctrl`

## Requirements
- R1: After reset, fuses 0 to 87 read 1. Fuses 88 to 95 hold parameter MFR_ID, with bit i of MFR_ID at fuse 88+i. Fuses 96 to 127 hold parameter SERIAL, with bit i of SERIAL at fuse 96+i.
- R2: rd_data is combinational. Bit j of rd_data equals fuse 32*rd_word + j.
- R3: A permitted request (burn_req high, index below 88, guarding lock fuse unburned) clears fuse burn_idx at the clock edge that samples the strobe. burn_done is high in the following cycle.
- R4: A burned fuse never reads 1 again. Burning a fuse that is already 0 is accepted with burn_done and leaves the array unchanged.
- R5: A request for any fuse from 88 to 127 is rejected with burn_rej and changes no fuse, whatever the lock state.
- R6: When lock fuse k (k = burn_idx / 16) reads 0, a request for any fuse from 16k to 16k+15 is rejected with burn_rej and leaves the array unchanged.
- R7: Once lock fuse 0 is burned, every request for fuses 0 to 15 is rejected, so the lock fuses keep their values from then on.
- R8: While lock fuse 0 is unburned, lock fuses 6 and 7 can be burned. Burning them leaves every fuse below 88 writable unless another lock fuse forbids it.
- R9: In the cycle after each request, exactly one of burn_done and burn_rej is high. In the cycle after a cycle with no request, both are low.
- R10: Requests may arrive in back-to-back cycles. Each is decided against the array as left by the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the preload image |
| burn_req | input | 1 | Burn strobe, one request per cycle |
| burn_idx | input | 7 | Index of the fuse to burn |
| rd_word | input | 2 | Selects the 32-bit word on rd_data |
| rd_data | output | 32 | Selected fuse word |
| burn_done | output | 1 | One-cycle pulse: previous request accepted |
| burn_rej | output | 1 | One-cycle pulse: previous request refused |

## Verification
Directed requests come first. They burn a status fuse twice, aim at the identity and serial fields, burn lock fuses 6 and 7 and then an ordinary group-0 fuse, and lock groups 1 and 5 before probing inside them. These cases separate the fixed-region rule from the lock rule and from the repeated-burn rule. A long back-to-back random run with lock fuse 0 spared follows; it locks groups in arbitrary orders while status fuses are burned. Lock fuse 0 is then burned, and a second random run checks that the lock fuses stay frozen. After every cycle all four read words are compared, so any change at the wrong place shows up at once.

// File: rtl/fuse_otp_pkg.sv
package fuse_otp_pkg;

  // Outcome of one burn request as seen one cycle later
  typedef enum logic [1:0] {
    RESP_IDLE = 2'b00,
    RESP_DONE = 2'b01,
    RESP_REJ  = 2'b10
  } burn_resp_e;

  // Fuses at or above the base belong to the factory-set fields
  function automatic logic in_fixed_region(int unsigned idx, int unsigned base);
    return idx >= base;
  endfunction

  // Group number of a fuse for a given group size, expressed as a shift
  function automatic int unsigned group_of(int unsigned idx, int unsigned shift);
    return idx >> shift;
  endfunction

endpackage

// File: rtl/fuse_otp_gate.sv
module fuse_otp_gate
  import fuse_otp_pkg::*;
#(
  parameter int unsigned NUM_FUSES  = 128,
  parameter int unsigned GROUP_SIZE = 16,
  parameter int unsigned FIXED_BASE = 88,
  localparam int unsigned IDX_W     = $clog2(NUM_FUSES),
  localparam int unsigned NUM_LOCKS = NUM_FUSES / GROUP_SIZE,
  localparam int unsigned GRP_SH    = $clog2(GROUP_SIZE)
) (
  input  logic                 req,
  input  logic [IDX_W-1:0]     idx,
  input  logic [NUM_LOCKS-1:0] lock_fuses,
  output logic                 grant,
  output logic                 deny
);

  // Per-group open flag: a group accepts burns while its lock fuse reads 1
  // and its first fuse lies below the fixed region.
  logic [NUM_LOCKS-1:0] group_open;

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_grp
    localparam bit GRP_REACHABLE = (g * GROUP_SIZE) < FIXED_BASE;
    if (GRP_REACHABLE) begin : g_live
      assign group_open[g] = lock_fuses[g];
    end else begin : g_dead
      assign group_open[g] = 1'b0;
    end
  end

  logic fixed_hit;
  logic grp_ok;

  always_comb begin
    fixed_hit = in_fixed_region(int'(idx), FIXED_BASE);
    grp_ok    = group_open[group_of(int'(idx), GRP_SH)];
    grant     = req && !fixed_hit && grp_ok;
    deny      = req && !grant;
  end

endmodule

// File: rtl/fuse_otp_store.sv
module fuse_otp_store #(
  parameter int unsigned          NUM_FUSES = 128,
  parameter logic [NUM_FUSES-1:0] INIT      = '1,
  parameter int unsigned          FIXED_BASE = 88,
  localparam int unsigned         IDX_W     = $clog2(NUM_FUSES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_en,
  input  logic [IDX_W-1:0]     clr_idx,
  output logic [NUM_FUSES-1:0] fuses
);

  // One flop per fuse; the only transition allowed is 1 -> 0
  for (genvar b = 0; b < NUM_FUSES; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= INIT[b];
      end else if (clr_en && (clr_idx == IDX_W'(b))) begin
        bit_q <= 1'b0;
      end
    end
    assign fuses[b] = bit_q;
  end

  AST_NO_REGROW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fuses & ~$past(fuses)) == '0)); // R4

  AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(fuses ^ $past(fuses)) <= 1)); // R10

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(fuses[NUM_FUSES-1:FIXED_BASE])); // R5

endmodule

// File: rtl/fuse_otp_rdmux.sv
module fuse_otp_rdmux #(
  parameter int unsigned  NUM_FUSES = 128,
  parameter int unsigned  WORD_W    = 32,
  localparam int unsigned NUM_WORDS = NUM_FUSES / WORD_W,
  localparam int unsigned SEL_W     = $clog2(NUM_WORDS)
) (
  input  logic [NUM_FUSES-1:0] fuses,
  input  logic [SEL_W-1:0]     sel,
  output logic [WORD_W-1:0]    data
);

  logic [WORD_W-1:0] words [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words[w] = fuses[w*WORD_W +: WORD_W];
  end

  assign data = words[sel];

endmodule

// File: rtl/fuse_otp_ctrl.sv
module fuse_otp_ctrl
  import fuse_otp_pkg::*;
#(
  parameter int unsigned   NUM_FUSES  = 128,
  parameter int unsigned   GROUP_SIZE = 16,
  parameter int unsigned   WORD_W     = 32,
  parameter int unsigned   MFR_W      = 8,
  parameter int unsigned   SN_W       = 32,
  parameter logic [MFR_W-1:0] MFR_ID  = 8'hA5,
  parameter logic [SN_W-1:0]  SERIAL  = 32'h1234_5678,
  localparam int unsigned  IDX_W      = $clog2(NUM_FUSES),
  localparam int unsigned  SEL_W      = $clog2(NUM_FUSES / WORD_W),
  localparam int unsigned  NUM_LOCKS  = NUM_FUSES / GROUP_SIZE,
  localparam int unsigned  GRP_SH     = $clog2(GROUP_SIZE),
  localparam int unsigned  FIXED_BASE = NUM_FUSES - MFR_W - SN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              burn_req,
  input  logic [IDX_W-1:0]  burn_idx,
  input  logic [SEL_W-1:0]  rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic              burn_done,
  output logic              burn_rej
);

  localparam logic [NUM_FUSES-1:0] PRELOAD = {SERIAL, MFR_ID, {FIXED_BASE{1'b1}}};

  // Named internal events for the assertions
  logic                 burn_grant;
  logic                 burn_deny;
  logic [NUM_FUSES-1:0] fuse_vec;
  logic [NUM_LOCKS-1:0] lock_vec;
  burn_resp_e           resp_q;

  assign lock_vec = fuse_vec[NUM_LOCKS-1:0];

  fuse_otp_gate #(
    .NUM_FUSES (NUM_FUSES),
    .GROUP_SIZE(GROUP_SIZE),
    .FIXED_BASE(FIXED_BASE)
  ) i_gate (
    .req       (burn_req),
    .idx       (burn_idx),
    .lock_fuses(lock_vec),
    .grant     (burn_grant),
    .deny      (burn_deny)
  );

  fuse_otp_store #(
    .NUM_FUSES (NUM_FUSES),
    .INIT      (PRELOAD),
    .FIXED_BASE(FIXED_BASE)
  ) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_en (burn_grant),
    .clr_idx(burn_idx),
    .fuses  (fuse_vec)
  );

  fuse_otp_rdmux #(
    .NUM_FUSES(NUM_FUSES),
    .WORD_W   (WORD_W)
  ) i_rdmux (
    .fuses(fuse_vec),
    .sel  (rd_word),
    .data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_q <= RESP_IDLE;
    end else if (burn_grant) begin
      resp_q <= RESP_DONE;
    end else if (burn_deny) begin
      resp_q <= RESP_REJ;
    end else begin
      resp_q <= RESP_IDLE;
    end
  end

  assign burn_done = (resp_q == RESP_DONE);
  assign burn_rej  = (resp_q == RESP_REJ);

  AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(burn_done && burn_rej)); // R9

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    burn_req |=> (burn_done || burn_rej)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !burn_req |=> (!burn_done && !burn_rej)); // R9

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (burn_req && burn_grant) |=> !fuse_vec[$past(burn_idx)]); // R3

  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (burn_req && !lock_vec[group_of(int'(burn_idx), GRP_SH)]) |=>
      ($stable(fuse_vec) && burn_rej)); // R6

  AST_REJ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    burn_deny |=> $stable(fuse_vec)); // R5

endmodule

// File: tb/test_fuse_otp_ctrl.sv
`timescale 1ns/100ps
module test_fuse_otp_ctrl;

  localparam logic [7:0]  T_MFR = 8'h3C;
  localparam logic [31:0] T_SN  = 32'hC0DE_1F2E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        burn_req = 1'b0;
  logic [6:0]  burn_idx = '0;
  logic [1:0]  rd_word = '0;
  logic [31:0] rd_data;
  logic        burn_done;
  logic        burn_rej;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [127:0] model;
  bit    exp_done, exp_rej;
  string cur_tag;

  always #2.5 clk = ~clk;

  fuse_otp_ctrl #(.MFR_ID(T_MFR), .SERIAL(T_SN)) i_fuse_otp_ctrl (
    .clk(clk), .rst_n(rst_n), .burn_req(burn_req), .burn_idx(burn_idx),
    .rd_word(rd_word), .rd_data(rd_data), .burn_done(burn_done), .burn_rej(burn_rej)
  );

  // Permission restated: fixed field above 87, otherwise look up guarding lock fuse
  function automatic bit may_burn(input logic [127:0] m, input int idx);
    if (idx > 87) return 0;
    return m[idx / 16] == 1'b1;
  endfunction

  function automatic string tag_for(input logic [127:0] m, input bit req, input int idx);
    if (!req) return "R9";
    if (idx > 87) return "R5";
    if (idx < 16 && m[0] == 1'b0) return "R7";
    if (m[idx / 16] == 1'b0) return "R6";
    if (idx == 6 || idx == 7) return "R8";
    if (m[idx] == 1'b0) return "R4";
    return "R3";
  endfunction

  task automatic check_outputs();
    checks++;
    if (burn_done !== exp_done || burn_rej !== exp_rej) begin
      errors++;
      $display("FAIL %s/R9 response done,rej actual %b%b expected %b%b",
               cur_tag, burn_done, burn_rej, exp_done, exp_rej);
    end
    for (int w = 0; w < 4; w++) begin
      rd_word = 2'(w);
      #0.4;
      checks++;
      if (rd_data !== model[w*32 +: 32]) begin
        errors++;
        $display("FAIL %s/R2 word %0d actual %h expected %h",
                 cur_tag, w, rd_data, model[w*32 +: 32]);
      end
    end
  endtask

  // One cycle: check the result of the previous request, then present the next (R10)
  task automatic step(input bit req, input int idx);
    @(negedge clk);
    check_outputs();
    cur_tag  = tag_for(model, req, idx);
    exp_done = req && may_burn(model, idx);
    exp_rej  = req && !may_burn(model, idx);
    if (exp_done) model[idx] = 1'b0;
    burn_req = req;
    burn_idx = 7'(idx);
  endtask

  initial begin
    int n;
    void'($urandom(32'd20240611));
    model    = {T_SN, T_MFR, {88{1'b1}}};
    exp_done = 0;
    exp_rej  = 0;
    cur_tag  = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // First step checks the reset image (R1)
    step(1, 40);          // R3 status burn
    step(1, 40);          // R4 repeat burn
    step(1, 88);          // R5 manufacturer byte
    step(1, 127);         // R5 serial top
    step(0, 0);           // R9 idle
    step(1, 6);           // R8
    step(1, 7);           // R8
    step(1, 9);           // R8 group 0 still open
    step(1, 1);           // lock group 1
    step(1, 20);          // R6
    step(1, 31);          // R6
    step(1, 5);           // lock group 5
    step(1, 85);          // R6
    step(1, 79);          // R3 group 4 still open
    // Random back-to-back run sparing lock fuse 0 (R10)
    for (int i = 0; i < 400; i++) begin
      n = 1 + int'($urandom % 127);
      step(($urandom % 4) != 0, n);
    end
    step(1, 0);           // freeze lock fuses
    step(1, 3);           // R7
    step(1, 15);          // R7
    for (int i = 0; i < 300; i++) begin
      n = int'($urandom % 128);
      step(($urandom % 4) != 0, n);
    end
    step(0, 0);
    step(0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule